// File: doc/BRIEF.md
# Dual Snapshot Counter with Byte Readout

This block holds two independent up-counters, A and B, that advance on single-cycle count pulses in one system clock domain. A capture pulse freezes both counts at once into a holding register, and a narrow byte port reads that held value back one byte at a time. Each byte has its own active-low select. With no select low, the port is released, which is modelled as an output-enable flag.

Counter A drives an active-low ripple-carry output while it holds its all-ones value. Counter B advances only while its active-low enable is low. To join the two into one counter of twice the width, tie that carry to B's enable and issue the A and B count pulses together. An active-low clear empties both counters at once and does not wait for the clock. It leaves the held snapshot alone, so the last captured value stays readable.

The readout is addressed, not streamed, so the byte port has no valid/ready pair and no back-pressure. A byte is valid as long as its select is held low, and it changes only on a capture.

Top module: `dual_snap_counter`

## Requirements
- R1: While clr_n and rst_n are high, each counter adds one, modulo 2^CNT_W, on every clock edge where its own count pulse is high. A pulse to one counter never changes the other.
- R2: Counter B advances on a B count pulse only when cnt_b_en_n is low at that edge. With cnt_b_en_n high, B holds its value.
- R3: rco_a_n is low exactly while counter A holds all ones. With the carry tied to cnt_b_en_n and both count pulses issued together, the pair counts as one 2*CNT_W-bit value: A goes FFFF to 0000 and B goes 0100 to 0101 on the same edge.
- R4: clr_n low sets both counters to zero without waiting for the clock, which releases rco_a_n high. Count pulses have no effect while clr_n is low. The held snapshot does not change.
- R5: A capture pulse loads the held register with {B, A}. Select lane i drives bits [8i+7:8i] of that value: sel_n[0] drives A low, sel_n[1] A high, sel_n[2] B low and sel_n[3] B high.
- R6: When a capture pulse and a count pulse share an edge, the snapshot holds the counts from before that edge's increment.
- R7: With exactly one select low, rd_oe is 1, sel_err is 0 and rd_data carries that lane's byte.
- R8: With all selects high, rd_oe is 0, sel_err is 0 and rd_data is 0.
- R9: With two or more selects low, sel_err is 1. rd_data is then unspecified.
- R10: rst_n low clears both counters and the held snapshot to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears everything |
| clr_n | input | 1 | Asynchronous counter clear, active low |
| cnt_a_pulse | input | 1 | Count pulse for counter A |
| cnt_b_pulse | input | 1 | Count pulse for counter B |
| cnt_b_en_n | input | 1 | Active-low enable for counter B |
| cap_pulse | input | 1 | Capture both counts into the snapshot |
| sel_n | input | LANES (4) | Active-low byte lane selects |
| rco_a_n | output | 1 | Active-low ripple carry, low while A is all ones |
| rd_data | output | BYTE_W (8) | Selected snapshot byte |
| rd_oe | output | 1 | Output enable; 0 means the port is released |
| sel_err | output | 1 | More than one select is low |

## Verification
The bench builds the block at its default widths: 16-bit counters and 8-bit lanes, which give four select lanes. At these widths the full 65,535-step climb of counter A to FFFF fits inside the run, so the cascade into a counter B preset to 0100 is exercised through a real wrap and not a forced value. Every legal lane, the idle case and two illegal select patterns are each read against counts the bench tracks itself.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int DEF_CNT_W  = 16;
  localparam int DEF_BYTE_W = 8;

  function automatic int lanes_for(input int cnt_w, input int byte_w);
    return 2 * (cnt_w / byte_w);
  endfunction
endpackage

// File: rtl/dsc_counter.sv
module dsc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         step,
  input  logic         en_n,
  output logic [W-1:0] count,
  output logic         full
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      count <= '0;
    else if (step && !en_n)
      count <= count + 1'b1;
  end

  assign full = &count;
endmodule

// File: rtl/dsc_snapshot.sv
module dsc_snapshot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (cap)
      q <= d;
  end
endmodule

// File: rtl/dsc_lane_mux.sv
module dsc_lane_mux #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic [LANES-1:0]        sel_n,
  input  logic [LANES*BYTE_W-1:0] d,
  output logic [BYTE_W-1:0]       data,
  output logic                    oe,
  output logic                    err
);
  logic [LANES-1:0]  hit;
  logic [BYTE_W-1:0] masked [LANES];

  assign hit = ~sel_n;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign masked[i] = hit[i] ? d[i*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    int n;
    n    = 0;
    data = '0;
    for (int i = 0; i < LANES; i++) begin
      data = data | masked[i];
      if (hit[i]) n = n + 1;
    end
    oe  = (n != 0);
    err = (n > 1);
  end
endmodule

// File: rtl/dual_snap_counter.sv
module dual_snap_counter
  import dsc_pkg::*;
#(
  parameter int CNT_W  = DEF_CNT_W,
  parameter int BYTE_W = DEF_BYTE_W,
  parameter int LANES  = lanes_for(CNT_W, BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              cnt_a_pulse,
  input  logic              cnt_b_pulse,
  input  logic              cnt_b_en_n,
  input  logic              cap_pulse,
  input  logic [LANES-1:0]  sel_n,
  output logic              rco_a_n,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              sel_err
);
  localparam int SNAP_W = 2 * CNT_W;

  logic             clr_all_n;
  logic [CNT_W-1:0] cnt_a_q;
  logic [CNT_W-1:0] cnt_b_q;
  logic             a_full;
  logic             b_full;
  logic [SNAP_W-1:0] snap_q;

  assign clr_all_n = rst_n & clr_n;

  dsc_counter #(.W(CNT_W)) u_cnt_a (
    .clk   (clk),
    .clr_n (clr_all_n),
    .step  (cnt_a_pulse),
    .en_n  (1'b0),
    .count (cnt_a_q),
    .full  (a_full)
  );

  dsc_counter #(.W(CNT_W)) u_cnt_b (
    .clk   (clk),
    .clr_n (clr_all_n),
    .step  (cnt_b_pulse),
    .en_n  (cnt_b_en_n),
    .count (cnt_b_q),
    .full  (b_full)
  );

  assign rco_a_n = ~a_full;

  dsc_snapshot #(.W(SNAP_W)) u_snap (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap_pulse),
    .d     ({cnt_b_q, cnt_a_q}),
    .q     (snap_q)
  );

  dsc_lane_mux #(.BYTE_W(BYTE_W), .LANES(LANES)) u_mux (
    .sel_n (sel_n),
    .d     (snap_q),
    .data  (rd_data),
    .oe    (rd_oe),
    .err   (sel_err)
  );

  logic unused_b_full;
  assign unused_b_full = b_full;
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int CNT_W = 16,
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr_n,
  input logic               cnt_a_pulse,
  input logic               cnt_b_pulse,
  input logic               cnt_b_en_n,
  input logic               cap_pulse,
  input logic [LANES-1:0]   sel_n,
  input logic               rco_a_n,
  input logic               rd_oe,
  input logic               sel_err,
  input logic [CNT_W-1:0]   cnt_a,
  input logic [CNT_W-1:0]   cnt_b,
  input logic [2*CNT_W-1:0] snap
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (&sel_n) |-> (!rd_oe && !sel_err)); // R8

  AST_MULTI_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~sel_n) > 1) |-> sel_err); // R9

  AST_SINGLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~sel_n) == 1) |-> (rd_oe && !sel_err)); // R7

  AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_pulse |=> $stable(snap)); // R5

  AST_SNAP_PRE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_pulse && clr_n) |=> (snap == {$past(cnt_b), $past(cnt_a)})); // R6

  AST_B_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && (cnt_b_en_n || !cnt_b_pulse)) |=> (!clr_n || $stable(cnt_b))); // R2

  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !rco_a_n && cnt_a_pulse) |=> (!clr_n || (cnt_a == '0 && rco_a_n))); // R3
endmodule

bind dual_snap_counter dsc_checker #(.CNT_W(CNT_W), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_n       (clr_n),
  .cnt_a_pulse (cnt_a_pulse),
  .cnt_b_pulse (cnt_b_pulse),
  .cnt_b_en_n  (cnt_b_en_n),
  .cap_pulse   (cap_pulse),
  .sel_n       (sel_n),
  .rco_a_n     (rco_a_n),
  .rd_oe       (rd_oe),
  .sel_err     (sel_err),
  .cnt_a       (cnt_a_q),
  .cnt_b       (cnt_b_q),
  .snap        (snap_q)
);

// File: tb/dual_snap_counter_test.sv
`timescale 1ns/1ps
module dual_snap_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_n = 1'b1;
  logic       a_p = 1'b0;
  logic       b_p = 1'b0;
  logic       b_en_man = 1'b1;
  logic       chain = 1'b0;
  logic       cap = 1'b0;
  logic [3:0] sel_n = 4'hF;
  logic       rco_n;
  logic [7:0] rd_data;
  logic       rd_oe;
  logic       sel_err;
  logic       b_en_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  assign b_en_n = chain ? rco_n : b_en_man;

  always #2 clk = ~clk;

  dual_snap_counter uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_n       (clr_n),
    .cnt_a_pulse (a_p),
    .cnt_b_pulse (b_p),
    .cnt_b_en_n  (b_en_n),
    .cap_pulse   (cap),
    .sel_n       (sel_n),
    .rco_a_n     (rco_n),
    .rd_data     (rd_data),
    .rd_oe       (rd_oe),
    .sel_err     (sel_err)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Hold the given pulses high for n rising edges, starting from a falling edge.
  task automatic drive(input logic a, input logic b, input logic c, input int n);
    @(negedge clk);
    a_p = a; b_p = b; cap = c;
    repeat (n) @(negedge clk);
    a_p = 0; b_p = 0; cap = 0;
  endtask

  task automatic read_snap(input string req, input logic [15:0] ea, input logic [15:0] eb);
    logic [31:0] exp;
    exp = {eb, ea};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      sel_n = ~(4'b0001 << i);
      #0.5;
      check({req, " lane data"}, {24'h0, rd_data}, {24'h0, exp[i*8 +: 8]});
      check({req, " lane oe/err"}, {30'h0, rd_oe, sel_err}, 32'h2);
    end
    @(negedge clk);
    sel_n = 4'hF;
  endtask

  task automatic capture_and_read(input string req, input logic [15:0] ea, input logic [15:0] eb);
    drive(0, 0, 1, 1);
    read_snap(req, ea, eb);
  endtask

  task automatic clear_all();
    @(negedge clk); clr_n = 0;
    @(negedge clk); clr_n = 1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 reset oe", {31'h0, rd_oe}, 32'h0);
    check("R10 reset rco", {31'h0, rco_n}, 32'h1);
    read_snap("R10 reset snapshot", 16'h0000, 16'h0000);
  endtask

  task automatic t_independent();
    clear_all();
    b_en_man = 0;
    drive(1, 0, 0, 5);
    drive(0, 1, 0, 3);
    capture_and_read("R1 independent counts", 16'h0005, 16'h0003);
    drive(1, 1, 0, 2);
    capture_and_read("R1 joint pulses", 16'h0007, 16'h0005);
  endtask

  task automatic t_b_enable();
    b_en_man = 1;
    drive(0, 1, 0, 4);
    capture_and_read("R2 B held while enable high", 16'h0007, 16'h0005);
    b_en_man = 0;
    drive(0, 1, 0, 2);
    capture_and_read("R2 B counts while enable low", 16'h0007, 16'h0007);
  endtask

  task automatic t_coincide();
    drive(1, 0, 1, 1);
    read_snap("R6 capture with count uses old A", 16'h0007, 16'h0007);
    capture_and_read("R6 later capture sees increment", 16'h0008, 16'h0007);
  endtask

  task automatic t_clear();
    capture_and_read("R4 pre-clear snapshot", 16'h0008, 16'h0007);
    @(negedge clk); a_p = 1;
    repeat (5) @(negedge clk);
    clr_n = 0;
    #0.5;
    check("R4 rco released in clear", {31'h0, rco_n}, 32'h1);
    repeat (2) @(negedge clk);
    clr_n = 1;
    repeat (3) @(negedge clk);
    a_p = 0;
    read_snap("R4 snapshot kept after clear", 16'h0008, 16'h0007);
    capture_and_read("R4 count restarts after clear", 16'h0003, 16'h0000);
  endtask

  task automatic t_selects();
    @(negedge clk); sel_n = 4'hF; #0.5;
    check("R8 idle oe", {31'h0, rd_oe}, 32'h0);
    check("R8 idle data", {24'h0, rd_data}, 32'h0);
    check("R8 idle err", {31'h0, sel_err}, 32'h0);
    @(negedge clk); sel_n = 4'b1100; #0.5;
    check("R9 two selects low", {31'h0, sel_err}, 32'h1);
    @(negedge clk); sel_n = 4'b0000; #0.5;
    check("R9 all selects low", {31'h0, sel_err}, 32'h1);
    @(negedge clk); sel_n = 4'b1110; #0.5;
    check("R7 single select no err", {31'h0, sel_err}, 32'h0);
    @(negedge clk); sel_n = 4'hF;
  endtask

  task automatic t_cascade();
    clear_all();
    chain = 0; b_en_man = 0;
    drive(0, 1, 0, 256);
    chain = 1;
    drive(1, 1, 0, 65535);
    @(negedge clk);
    check("R3 carry low at FFFF", {31'h0, rco_n}, 32'h0);
    capture_and_read("R3 before wrap", 16'hFFFF, 16'h0100);
    drive(1, 1, 0, 1);
    @(negedge clk);
    check("R3 carry high after wrap", {31'h0, rco_n}, 32'h1);
    capture_and_read("R3 wrap moves B", 16'h0000, 16'h0101);
    drive(1, 1, 0, 1);
    capture_and_read("R3 B steady after wrap", 16'h0001, 16'h0101);
    chain = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_independent();
    t_b_enable();
    t_coincide();
    t_clear();
    t_selects();
    t_cascade();
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule